// File: doc/BRIEF.md
# Four-Lane Framed Serial Sample Transmitter

This block takes one parallel 12-bit sample per channel and shifts it out one bit per cycle of a bit-rate clock, with one serial lane per channel. Four lanes run in lockstep and share two timing outputs. The first is a frame marker that is high for the first bit of every word. The second is a bit clock that toggles every cycle, so it runs at half the bit rate and data moves on both of its edges.

Two word formats are available. The short format sends the 12 sample bits, so the bit clock runs at 6 times the sample rate. The long format sends 14 bits: two zero pad bits sit above the sample's most significant bit, and the bit clock runs at 7 times the sample rate. The bit order can be most significant first or least significant first. Words follow one another with no idle bits between them.

The samples and both mode controls are read only on the clock edge that starts a word. A change to any of them therefore takes effect at the next frame boundary, and a change in the middle of a word does not disturb the word in flight.

Top module: `adc_serial_tx`

## Requirements
- R1: While `rst` is high, at the following clock edge `lane_o` is all zero and `frame_o` and `bclk_o` are low.
- R2: `frame_o` is high for exactly one cycle per word, together with the word's first bit. Frame pulses are 12 cycles apart for a short word (`wide_i`=0) and 14 cycles apart for a long word (`wide_i`=1).
- R3: With `wide_i`=0 and `lsb_first_i`=0, a lane sends sample bit 11 first and then bits 10 down to 0.
- R4: With `wide_i`=0 and `lsb_first_i`=1, a lane sends sample bit 0 first and then bits 1 up to 11.
- R5: With `wide_i`=1 and `lsb_first_i`=0, a lane sends two 0 bits, then sample bits 11 down to 0.
- R6: With `wide_i`=1 and `lsb_first_i`=1, a lane sends sample bits 0 up to 11, then two 0 bits.
- R7: Words are back to back. The cycle after a word's last bit carries the next word's first bit, with `frame_o` high.
- R8: After reset, `bclk_o` inverts on every clock edge. It is high in every cycle where `frame_o` is high, so it is high on even bit positions (counting from 0) and low on odd ones.
- R9: `sample_i`, `wide_i` and `lsb_first_i` are sampled only on the edge that starts a word: the first edge after reset, and after that the edge that ends the previous word's last bit. Changes at any other time have no effect on the word being sent.
- R10: Lane i carries `sample_i[12*i +: 12]`, and all lanes send their bits in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_i | input | 1 | 1 selects 14-bit words with two zero pad bits, 0 selects 12-bit words |
| lsb_first_i | input | 1 | 1 sends bit 0 first, 0 sends bit 11 first |
| sample_i | input | 48 | Four packed 12-bit samples, lane 0 in the low bits |
| lane_o | output | 4 | Serial data, one bit per lane |
| frame_o | output | 1 | High during the first bit of each word |
| bclk_o | output | 1 | Bit clock at half the bit rate |

## Verification
All outputs are registered. Inputs present before the edge that starts a word show up one cycle later: `frame_o` and the first bit appear in the cycle that follows that edge, and bit k appears k cycles after that. The bench drives inputs and samples outputs at the falling edge. A word's new sample and mode are driven in the cycle whose sample shows `frame_o` high, so they are captured at the edge that follows that word's last bit. The bench then compares every bit of every lane, and the bit clock level, at each later falling edge. Inputs are also changed and restored in the middle of a word to show that they are only read at the word edge, and the frame spacing checks that the bits of consecutive words are contiguous.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  typedef struct packed {
    logic wide;       // 1: long word with zero pad on the high side
    logic lsb_first;  // 1: send bit 0 first
  } ser_mode_t;
endpackage

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl #(
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wide_i,
  output logic load_o,
  output logic frame_o,
  output logic bclk_o
);
  localparam int WORD_W = SAMPLE_W + PAD_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(WORD_W - 1);

  logic             running_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] last_q;

  // a word starts after reset or once the last bit position is reached
  assign load_o = !running_q || (pos_q == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      pos_q     <= '0;
      last_q    <= '0;
      frame_o   <= 1'b0;
      bclk_o    <= 1'b0;
    end else begin
      running_q <= 1'b1;
      bclk_o    <= ~bclk_o;
      frame_o   <= load_o;
      if (load_o) begin
        pos_q  <= '0;
        last_q <= wide_i ? LAST_LONG : LAST_SHORT;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import adc_ser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  ser_mode_t           mode_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                bit_o
);
  localparam int WORD_W = SAMPLE_W + PAD_W;

  // word arranged in send order: bit 0 leaves first
  logic [WORD_W-1:0] fmt;
  logic [WORD_W-1:0] shreg_q;

  always_comb begin
    fmt = '0;
    for (int k = 0; k < SAMPLE_W; k++) begin
      if (mode_i.lsb_first)
        fmt[k] = sample_i[k];
      else if (mode_i.wide)
        fmt[PAD_W + k] = sample_i[SAMPLE_W - 1 - k];
      else
        fmt[k] = sample_i[SAMPLE_W - 1 - k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      bit_o   <= 1'b0;
    end else if (load_i) begin
      bit_o   <= fmt[0];
      shreg_q <= {1'b0, fmt[WORD_W-1:1]};
    end else begin
      bit_o   <= shreg_q[0];
      shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
    end
  end
endmodule

// File: rtl/adc_serial_tx.sv
module adc_serial_tx
  import adc_ser_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wide_i,
  input  logic                      lsb_first_i,
  input  logic [LANES*SAMPLE_W-1:0] sample_i,
  output logic [LANES-1:0]          lane_o,
  output logic                      frame_o,
  output logic                      bclk_o
);
  logic      load;
  ser_mode_t mode;

  assign mode.wide      = wide_i;
  assign mode.lsb_first = lsb_first_i;

  ser_frame_ctrl #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wide_i (wide_i),
    .load_o (load),
    .frame_o(frame_o),
    .bclk_o (bclk_o)
  );

  // R10: one serializer per lane, all driven by the shared load strobe
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser_lane #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .mode_i  (mode),
      .sample_i(sample_i[g*SAMPLE_W +: SAMPLE_W]),
      .bit_o   (lane_o[g])
    );
  end
endmodule

// File: rtl/adc_serial_tx_chk.sv
module adc_serial_tx_chk #(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 12,
  parameter int PAD_W    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] lane_o,
  input logic             frame_o,
  input logic             bclk_o
);
  localparam int WORD_W = SAMPLE_W + PAD_W;

  logic       run_q;
  logic [4:0] cnt_q;   // cycles since the last frame marker

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (frame_o)
        cnt_q <= 5'd1;
      else if (cnt_q != 5'd0 && cnt_q != 5'd31)
        cnt_q <= cnt_q + 5'd1;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (lane_o == '0 && !frame_o && !bclk_o));

  p_frame_period_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_o && cnt_q != 5'd0) |-> (cnt_q == 5'(SAMPLE_W) || cnt_q == 5'(WORD_W)));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 5'(WORD_W));

  p_bclk_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (bclk_o != $past(bclk_o)));

  p_bclk_frame_r8: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> bclk_o);
endmodule

bind adc_serial_tx adc_serial_tx_chk #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .lane_o (lane_o),
  .frame_o(frame_o),
  .bclk_o (bclk_o)
);

// File: tb/adc_serial_tx_tb.sv
`timescale 1ns/1ps
module adc_serial_tx_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wide_i, lsb_first_i;
  logic [47:0] sample_i;
  logic [3:0]  lane_o;
  logic        frame_o, bclk_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;  // 250 MHz

  adc_serial_tx u_dut (
    .clk(clk), .rst(rst), .wide_i(wide_i), .lsb_first_i(lsb_first_i),
    .sample_i(sample_i), .lane_o(lane_o), .frame_o(frame_o), .bclk_o(bclk_o)
  );

  function automatic logic exp_bit(logic [11:0] s, logic w, logic l, int k);
    if (l) return (k < 12) ? s[k] : 1'b0;
    if (w) return (k < 2) ? 1'b0 : s[13 - k];
    return s[11 - k];
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Checks one word whose inputs were captured earlier; drives the next word's
  // inputs while this word's first bit is on the lanes. When glitch is set,
  // the inputs are changed mid-word and restored before the word ends (R9).
  task automatic word(input logic [47:0] cur, input logic cw, input logic cl,
                      input logic [47:0] nxt, input logic nw, input logic nl,
                      input string req, input bit glitch);
    int len;
    len = cw ? 14 : 12;
    for (int k = 0; k < len; k++) begin
      logic [3:0] e;
      @(negedge clk);
      if (k == 0) begin
        sample_i = nxt; wide_i = nw; lsb_first_i = nl;
      end
      if (glitch && k == 3) begin
        sample_i = ~nxt; wide_i = ~nw; lsb_first_i = ~nl;
      end
      if (glitch && k == 7) begin
        sample_i = nxt; wide_i = nw; lsb_first_i = nl;
      end
      chk((k == 0) ? "R2/R7 frame at word start" : "R2 frame low mid-word",
          {3'b000, frame_o}, {3'b000, (k == 0)});
      chk("R8 bclk level", {3'b000, bclk_o}, {3'b000, (k % 2 == 0)});
      for (int i = 0; i < 4; i++) e[i] = exp_bit(cur[12*i +: 12], cw, cl, k);
      chk({req, "/R10 lane bits"}, lane_o, e);
    end
  endtask

  task automatic reset_check();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 reset lanes", lane_o, 4'b0000);
    chk("R1 reset frame/bclk", {2'b00, frame_o, bclk_o}, 4'b0000);
  endtask

  localparam logic [47:0] A = 48'h5A3_C81_0F7_E29;
  localparam logic [47:0] B = 48'hFFF_000_800_001;
  localparam logic [47:0] C = 48'h123_ABC_456_DEF;
  localparam logic [47:0] D = 48'h9E1_7B2_36C_A05;
  localparam logic [47:0] E = 48'hC3D_2F8_E17_4A6;
  localparam logic [47:0] F = 48'h0F0_F0F_AAA_555;
  localparam logic [47:0] G = 48'h7FF_801_3C3_B4D;

  initial begin
    rst = 1'b1; wide_i = 1'b0; lsb_first_i = 1'b0; sample_i = A;
    repeat (3) @(negedge clk);
    chk("R1 reset lanes", lane_o, 4'b0000);
    chk("R1 reset frame/bclk", {2'b00, frame_o, bclk_o}, 4'b0000);
    rst = 1'b0;
    word(A, 0, 0, B, 0, 0, "R3 short msb-first", 0);
    word(B, 0, 0, C, 0, 1, "R3 short msb-first", 0);
    word(C, 0, 1, D, 1, 0, "R4 short lsb-first", 0);
    word(D, 1, 0, E, 1, 1, "R5 long msb-first", 0);
    word(E, 1, 1, F, 0, 0, "R6/R9 long lsb-first with glitch", 1);
    word(F, 0, 0, G, 1, 1, "R9 short with glitch", 1);
    word(G, 1, 1, A, 0, 1, "R6 long lsb-first", 0);
    word(A, 0, 1, A, 0, 1, "R4 short lsb-first", 0);
    reset_check();
    sample_i = D; wide_i = 1'b1; lsb_first_i = 1'b0;
    @(negedge clk); rst = 1'b0;
    word(D, 1, 0, C, 0, 0, "R1/R5 restart after reset", 0);
    word(C, 0, 0, C, 0, 0, "R3 after long word", 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule